// File: doc/BRIEF.md
# Floppy Read-Channel Digital Data Separator

This block turns the raw read-pulse stream of a double-density floppy drive into a bit-cell clock and a matching data bit. It runs on the controller reference clock, nominally 8 MHz, where one 2 us bit cell spans sixteen ticks. Each read pulse passes through a two-flop synchroniser and a rising-edge detector, so a pulse of any width gives one single-cycle event.

A modulo-CELL_TICKS phase counter marks out the recovered cell. The counter does not filter the phase of an incoming transition over time. Each transition reloads the counter to mid-cell at once, so the next cell boundary falls half a cell after the transition. At every boundary the block raises a one-cycle shift strobe. Alongside it the data line is 1 when the cell just closed held a transition and 0 when it did not. A downstream shift register loads the data line on each strobe and sees the raw MFM stream of clock and data bits. Pulse spacings of two, three or four cells come out as a 1 followed by one, two or three 0s.

Top module: `fdsep_top`

## Requirements
- R1: While rst_ni is low, strobe_o and data_o are 0. Reset is asynchronous.
- R2: With no read pulses, strobe_o rises once every CELL_TICKS cycles (16 by default), and data_o is 0 at each of those strobes.
- R3: strobe_o is never high for two cycles in a row.
- R4: A read pulse held high for any number of cycles counts as one transition. It gives exactly one cell with data_o = 1.
- R5: If pulse_i rises before clock edge k, and no cell boundary is already pending in the next two cycles, strobe_o is high with data_o = 1 in the cycle after edge k + SYNC_STAGES + CELL_TICKS/2. With the defaults that is edge k+10.
- R6: data_o changes only together with a strobe. At a strobe it is 1 exactly when a transition was detected since the previous strobe.
- R7: Pulse spacings of n cells (n = 2, 3, 4), each off nominal by up to 6 clocks, give a 1 followed by n-1 zeros on successive strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Raw read pulse from the drive, asynchronous, active high |
| data_o | output | 1 | Raw cell bit, valid while strobe_o is high |
| strobe_o | output | 1 | One-cycle shift strobe at each recovered cell boundary |

## Verification
The main stimulus is a table of pulse spacings. It mixes exact 2, 3 and 4 cell intervals with intervals pushed early or late by up to six clocks. This separates a loop that snaps to each transition from one that keeps free-running cell timing, and it catches off-by-one errors in the cell count. Directed patterns cover the rest. An idle line shows the free-running period. A single pulse timed just after a boundary measures the exact snap latency. A pulse held high for many cycles must not be counted twice. A reset asserted during activity must clear both outputs at once.

// File: rtl/fdsep_pkg.sv
package fdsep_pkg;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_CELL_TICKS  = 16;

  typedef struct packed {
    logic strobe;
    logic data;
  } cell_evt_t;
endpackage

// File: rtl/fdsep_sync.sv
module fdsep_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic edge_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], pulse_i};
  end

  // last stage is the delayed copy used for rising-edge detection
  assign edge_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/fdsep_phase.sv
module fdsep_phase #(
  parameter int unsigned CELL_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  output logic wrap_o
);
  localparam int unsigned CNT_W = (CELL_TICKS > 2) ? $clog2(CELL_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_TICKS - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(CELL_TICKS / 2);

  logic [CNT_W-1:0] phase_q, phase_d;

  always_comb begin
    if (edge_i)              phase_d = MID;   // snap to mid-cell
    else if (phase_q == LAST) phase_d = '0;
    else                     phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign wrap_o = (phase_q == LAST) && !edge_i;
endmodule

// File: rtl/fdsep_cell.sv
module fdsep_cell
  import fdsep_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      edge_i,
  input  logic      wrap_i,
  output cell_evt_t evt_o
);
  logic pend_q;
  cell_evt_t evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      evt_q  <= '0;
    end else begin
      if (edge_i)      pend_q <= 1'b1;
      else if (wrap_i) pend_q <= 1'b0;
      evt_q.strobe <= wrap_i;
      if (wrap_i) evt_q.data <= pend_q;
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/fdsep_top.sv
module fdsep_top
  import fdsep_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned CELL_TICKS  = DEF_CELL_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic data_o,
  output logic strobe_o
);
  logic      edge_w;
  logic      wrap_w;
  cell_evt_t evt_w;

  fdsep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse_i),
    .edge_o (edge_w)
  );

  fdsep_phase #(.CELL_TICKS(CELL_TICKS)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .edge_i(edge_w),
    .wrap_o(wrap_w)
  );

  fdsep_cell u_cell (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .edge_i(edge_w),
    .wrap_i(wrap_w),
    .evt_o (evt_w)
  );

  assign strobe_o = evt_w.strobe;
  assign data_o   = evt_w.data;
endmodule

// File: rtl/fdsep_chk.sv
module fdsep_chk #(
  parameter int unsigned CELL_TICKS = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic edge_i,
  input logic strobe_i,
  input logic data_i
);
  localparam int unsigned GAP_W = $clog2(CELL_TICKS) + 2;
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(CELL_TICKS);

  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (strobe_i || edge_i)   gap_q <= '0;
      else if (gap_q != '1)     gap_q <= gap_q + 1'b1;
      if (edge_i)        seen_q <= 1'b1;
      else if (strobe_i) seen_q <= 1'b0;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!strobe_i && !data_i) else $error("reset outputs"); // R1
    end
  end

  AST_IDLE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP_MAX) else $error("strobe gap too long"); // R2

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> !strobe_i) else $error("strobe wider than one cycle"); // R3

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |-> $stable(data_i)) else $error("data moved off strobe"); // R6

  AST_DATA_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> (data_i == seen_q)) else $error("data disagrees with edges"); // R6
endmodule

bind fdsep_top fdsep_chk #(.CELL_TICKS(CELL_TICKS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .edge_i  (edge_w),
  .strobe_i(strobe_o),
  .data_i  (data_o)
);

// File: tb/fdsep_top_tb.sv
module fdsep_top_tb;
  localparam int CELL = 16;
  localparam int LAT  = 2 + CELL / 2;
  localparam int NVEC = 12;
  localparam int SP [NVEC] = '{32, 48, 64, 30, 35, 45, 52, 60, 68, 28, 38, 58};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pulse_i = 1'b0;
  logic data_o, strobe_o;

  int checks = 0;
  int fails  = 0;
  bit rec_en = 1'b0;
  logic rec [0:1023];
  int rec_n = 0;

  fdsep_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pulse_i(pulse_i),
    .data_o(data_o), .strobe_o(strobe_o)
  );

  always #4 clk_i = ~clk_i;

  always @(negedge clk_i)
    if (rec_en && strobe_o && rec_n < 1024) begin
      rec[rec_n] = data_o;
      rec_n = rec_n + 1;
    end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic send(input int sp);
    pulse_i = 1'b1;
    repeat (3) @(negedge clk_i);
    pulse_i = 1'b0;
    repeat (sp - 3) @(negedge clk_i);
  endtask

  task automatic wait_strobe();
    do @(negedge clk_i); while (!strobe_o);
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    int base, pos, n, ones;
    bit ok;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    check(strobe_o == 1'b0, "R1 strobe in reset", strobe_o, 0);
    check(data_o == 1'b0, "R1 data in reset", data_o, 0);
    rst_ni = 1'b1;

    // R2: idle period and zero data
    wait_strobe();
    check(data_o == 1'b0, "R2 idle data", data_o, 0);
    for (int k = 0; k < 2; k++) begin
      n = 0;
      do begin @(negedge clk_i); n++; end while (!strobe_o);
      check(n == CELL, "R2 idle period", n, CELL);
      check(data_o == 1'b0, "R2 idle data", data_o, 0);
    end

    // R5: snap latency measured from right after a boundary; R3 width
    pulse_i = 1'b1;
    n = 0;
    do begin @(posedge clk_i); n++; @(negedge clk_i); end while (!strobe_o && n < 40);
    pulse_i = 1'b0;
    check(n == LAT + 1, "R5 snap latency", n, LAT + 1);
    check(data_o == 1'b1, "R5 data at snapped boundary", data_o, 1);
    @(negedge clk_i);
    check(strobe_o == 1'b0, "R3 strobe width", strobe_o, 0);
    repeat (40) @(negedge clk_i);

    // R7 / R6: table of pulse spacings
    base = rec_n;
    rec_en = 1'b1;
    for (int i = 0; i < NVEC; i++) send(SP[i]);
    send(40);
    rec_en = 1'b0;
    pos = base;
    while (pos < rec_n && rec[pos] !== 1'b1) pos++;
    for (int i = 0; i < NVEC; i++) begin
      n = (SP[i] + CELL / 2) / CELL;
      ok = (pos + n <= rec_n) && (rec[pos] === 1'b1);
      for (int j = 1; j < n; j++) if (pos + j < rec_n && rec[pos + j] !== 1'b0) ok = 1'b0;
      check(ok, $sformatf("R7 spacing %0d cells", n), i, SP[i]);
      pos += n;
    end
    check(pos < rec_n && rec[pos] === 1'b1, "R6 final edge cell", pos, rec_n);

    // R4: long-held pulse counts once
    repeat (20) @(negedge clk_i);
    base = rec_n;
    rec_en = 1'b1;
    pulse_i = 1'b1;
    repeat (40) @(negedge clk_i);
    pulse_i = 1'b0;
    repeat (60) @(negedge clk_i);
    rec_en = 1'b0;
    ones = 0;
    for (int i = base; i < rec_n; i++) if (rec[i] === 1'b1) ones++;
    check(ones == 1, "R4 held pulse one event", ones, 1);

    // R1: reset during activity clears outputs at once
    pulse_i = 1'b1;
    repeat (2) @(negedge clk_i);
    pulse_i = 1'b0;
    repeat (LAT) @(negedge clk_i);
    #1 rst_ni = 1'b0;
    #1;
    check(strobe_o == 1'b0 && data_o == 1'b0, "R1 async reset", {strobe_o, data_o}, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule